// File: doc/BRIEF.md
# Keyed Watchdog Timer

The block is a watchdog counter with a small 16-bit register port. It counts a slow time base that reaches it as a one-cycle `tick_i` strobe, 32768 strobes per second. Software writes a timeout in half-second units to the control register and sets the enable bit. From then on it must service the watchdog by writing a two-word key to the service register. If it does not, the block pulses a software-reset output, an external-reset output, or both, according to the control bits, and it records that a timeout occurred.

A programmable lead time raises an interrupt a set number of half-second units before the expiry point. The occurred flag is sticky and is cleared by writing a one to it. Counting stops for as long as a wait, debug or low-power input is high, provided the matching stop bit is set. At the first clock after reset, the reset-status register samples a reset-cause vector from the system. A power-down enable bit is passed straight to an output.

Top module: `wdg_keyed`

## Requirements
- R1: After reset the control register and the interrupt-control register read 0, the miscellaneous register reads 1, and `irq_o`, `sw_rst_o` and `ext_rst_o` are low. At the first clock edge after `rst_ni` rises, the status register at offset 0x4 loads `cause_i` = {power-on, timeout, software}: bit 4 is power-on, bit 1 is timeout and bit 0 is software.
- R2: Register offsets are control 0x0, service 0x2, status 0x4, interrupt-control 0x6 and miscellaneous 0x8. Reads are combinational on `addr_i`. Control bit 6 always reads 0, the service register reads 0, and unmapped offsets read 0.
- R3: Control bits [15:8] hold a timeout N and bit 2 is the enable. After the write that sets the enable, an expiry occurs after (N+1) x UNIT_TICKS counted ticks. Only cycles with `tick_i` high are counted.
- R4: Once set, the enable bit stays set until reset. Writing 0 to it has no effect, and expiries continue.
- R5: Writing 0x5555 and then 0xAAAA to the service register reloads the counter, so the next expiry comes (N+1) x UNIT_TICKS ticks after the 0xAAAA write. Writes to other registers between the two words do not break the sequence.
- R6: Any word other than 0x5555 as the first write, or other than 0xAAAA as the second, returns the sequence to idle without a reload. This includes a repeated 0x5555.
- R7: While control bit 7 and `wait_i` are both high, or bit 1 and `dbg_i`, or bit 0 and `lp_i`, ticks are not counted. When the stop bit is clear, the mode input has no effect.
- R8: On expiry, `sw_rst_o` pulses unless control bit 4 is set. `ext_rst_o` pulses when control bit 3 is set and bit 5 is clear.
- R9: Each reset pulse lasts one cycle. After an expiry the counter reloads N and runs on, so the next expiry follows (N+1) x UNIT_TICKS ticks later.
- R10: When interrupt-control bit 15 is set and its lead field [7:0] L is nonzero, the occurred flag (bit 14) sets L units before the expiry point. `irq_o` is high while both the flag and the enable are set. With the enable clear or L = 0, the flag never sets.
- R11: Writing 1 to interrupt-control bit 14 clears the flag. Writing 0 to it leaves the flag unchanged.
- R12: Every expiry sets status bit 1, including an expiry where both reset outputs are suppressed.
- R13: Miscellaneous bit 0 is read/write, resets to 1 and drives `pd_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base strobe, one cycle per slow tick |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 4 | Register byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational on addr_i |
| wait_i | input | 1 | Wait-mode indication |
| dbg_i | input | 1 | Debug-mode indication |
| lp_i | input | 1 | Low-power-mode indication |
| cause_i | input | 3 | Reset cause {power-on, timeout, software} |
| irq_o | output | 1 | Pre-timeout interrupt |
| sw_rst_o | output | 1 | Software-reset pulse |
| ext_rst_o | output | 1 | External-reset pulse |
| pd_en_o | output | 1 | Power-down enable |

## Verification
Each expiry is registered once, so a reset pulse appears in the cycle after the edge on which the last unit ends. With a tick every cycle, that edge is exactly (N+1) x UNIT_TICKS edges after the enabling write or the completing 0xAAAA write. For the same reason the interrupt flag shows (N-L+1) x UNIT_TICKS edges after enable. Register writes take effect at the edge they are presented on, and reads are combinational.

The bench stamps each write with a free-running edge count and samples every output at the falling edge. It then compares edge-count differences against these formulas. Stalls shift the expected time by exactly the number of stalled edges.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned TMO_W = 8;
  localparam logic [3:0] ADDR_CTRL = 4'h0;
  localparam logic [3:0] ADDR_SVC  = 4'h2;
  localparam logic [3:0] ADDR_STAT = 4'h4;
  localparam logic [3:0] ADDR_IRQ  = 4'h6;
  localparam logic [3:0] ADDR_MISC = 4'h8;
  localparam logic [15:0] KEY_FIRST  = 16'h5555;
  localparam logic [15:0] KEY_SECOND = 16'hAAAA;

  typedef enum logic {KEY_IDLE, KEY_ARMED} key_state_e;

  typedef struct packed {
    logic [TMO_W-1:0] tmo;
    logic wait_stop;
    logic rsv;
    logic ext_mask;
    logic sw_mask;
    logic ext_sel;
    logic en;
    logic dbg_stop;
    logic lp_stop;
  } ctrl_t;
endpackage

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
  parameter int unsigned UNIT_TICKS = 16384
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  output logic unit_o
);
  localparam int unsigned CW = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(UNIT_TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign unit_o = step_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (step_i)   cnt_q <= unit_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdg_unit_cnt.sv
module wdg_unit_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         unit_i,
  input  logic [W-1:0] lead_i,
  output logic         expire_o,
  output logic         lead_hit_o
);
  logic [W-1:0] cnt_q;

  // a reload on the same edge wins over the unit strobe
  assign expire_o   = unit_i && !load_i && (cnt_q == '0);
  assign lead_hit_o = unit_i && !load_i && (lead_i != '0) && (cnt_q == lead_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (unit_i)  cnt_q <= (cnt_q == '0) ? load_val_i : cnt_q - 1'b1;
  end
endmodule

// File: rtl/wdg_key_seq.sv
module wdg_key_seq
  import wdg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        svc_wr_i,
  input  logic [15:0] data_i,
  output logic        done_o,
  output logic        armed_o
);
  key_state_e state_q;

  assign armed_o = (state_q == KEY_ARMED);
  assign done_o  = svc_wr_i && armed_o && (data_i == KEY_SECOND);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= KEY_IDLE;
    else if (svc_wr_i) begin
      if (state_q == KEY_IDLE && data_i == KEY_FIRST) state_q <= KEY_ARMED;
      else                                            state_q <= KEY_IDLE;
    end
  end
endmodule

// File: rtl/wdg_keyed.sv
module wdg_keyed
  import wdg_pkg::*;
#(
  parameter int unsigned UNIT_TICKS = 16384
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [3:0]  addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  input  logic        wait_i,
  input  logic        dbg_i,
  input  logic        lp_i,
  input  logic [2:0]  cause_i,
  output logic        irq_o,
  output logic        sw_rst_o,
  output logic        ext_rst_o,
  output logic        pd_en_o
);
  ctrl_t            ctrl_q, ctrl_wd;
  logic             wr, ctrl_wr, svc_wr, irq_wr, misc_wr;
  logic             en_rise, load, pause, step, unit;
  logic             expire, lead_hit, key_done, key_armed;
  logic [TMO_W-1:0] load_val;
  logic             irq_en_q, irq_flag_q;
  logic [TMO_W-1:0] lead_q;
  logic [2:0]       stat_q;
  logic             cap_done_q, misc_q;
  logic             sw_q, ext_q, to_q;
  logic             wdg_en, sw_mask;

  assign wr      = req_i && we_i;
  assign ctrl_wr = wr && (addr_i == ADDR_CTRL);
  assign svc_wr  = wr && (addr_i == ADDR_SVC);
  assign irq_wr  = wr && (addr_i == ADDR_IRQ);
  assign misc_wr = wr && (addr_i == ADDR_MISC);

  assign ctrl_wd  = ctrl_t'(wdata_i);
  assign wdg_en   = ctrl_q.en;
  assign sw_mask  = ctrl_q.sw_mask;
  assign en_rise  = ctrl_wr && ctrl_wd.en && !ctrl_q.en;
  assign load     = en_rise || (key_done && ctrl_q.en);
  assign load_val = en_rise ? ctrl_wd.tmo : ctrl_q.tmo;
  assign pause    = (ctrl_q.wait_stop && wait_i) || (ctrl_q.dbg_stop && dbg_i) ||
                    (ctrl_q.lp_stop && lp_i);
  assign step     = tick_i && ctrl_q.en && !pause;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (ctrl_wr) begin
      ctrl_q     <= ctrl_wd;
      ctrl_q.rsv <= 1'b0;
      ctrl_q.en  <= ctrl_wd.en || ctrl_q.en;
    end
  end

  wdg_key_seq u_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .svc_wr_i (svc_wr),
    .data_i   (wdata_i),
    .done_o   (key_done),
    .armed_o  (key_armed)
  );

  wdg_prescale #(.UNIT_TICKS(UNIT_TICKS)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (load),
    .step_i  (step),
    .unit_o  (unit)
  );

  wdg_unit_cnt #(.W(TMO_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .unit_i     (unit),
    .lead_i     (lead_q),
    .expire_o   (expire),
    .lead_hit_o (lead_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_q   <= 1'b0;
      irq_flag_q <= 1'b0;
      lead_q     <= '0;
    end else begin
      if (irq_wr) begin
        irq_en_q <= wdata_i[15];
        lead_q   <= wdata_i[TMO_W-1:0];
      end
      if (lead_hit && irq_en_q)           irq_flag_q <= 1'b1;
      else if (irq_wr && wdata_i[14])     irq_flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q  <= 1'b0;
      ext_q <= 1'b0;
      to_q  <= 1'b0;
    end else begin
      sw_q  <= expire && !ctrl_q.sw_mask;
      ext_q <= expire && ctrl_q.ext_sel && !ctrl_q.ext_mask;
      to_q  <= expire;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q     <= '0;
      cap_done_q <= 1'b0;
    end else if (!cap_done_q) begin
      stat_q     <= cause_i;
      cap_done_q <= 1'b1;
    end else if (expire) begin
      stat_q[1]  <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      misc_q <= 1'b1;
    else if (misc_wr) misc_q <= wdata_i[0];
  end

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: rdata_o = ctrl_q;
      ADDR_STAT: rdata_o = {11'b0, stat_q[2], 2'b00, stat_q[1], stat_q[0]};
      ADDR_IRQ:  rdata_o = {irq_en_q, irq_flag_q, {(14-TMO_W){1'b0}}, lead_q};
      ADDR_MISC: rdata_o = {15'b0, misc_q};
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o     = irq_flag_q && irq_en_q;
  assign sw_rst_o  = sw_q;
  assign ext_rst_o = ext_q;
  assign pd_en_o   = misc_q;
endmodule

// File: rtl/wdg_keyed_chk.sv
module wdg_keyed_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sw_rst_o,
  input logic ext_rst_o,
  input logic en_q,
  input logic sw_mask_q,
  input logic to_q,
  input logic stat_tout_q,
  input logic key_done,
  input logic key_armed
);
  p_sw_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_o |=> !sw_rst_o);
  p_ext_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rst_o |=> !ext_rst_o);
  p_en_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> en_q);
  p_sw_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_o |-> !$past(sw_mask_q));
  p_rst_needs_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_rst_o || ext_rst_o) |-> $past(en_q));
  p_tout_status_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_q |-> stat_tout_q);
  p_key_order_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_done |-> key_armed);
  p_key_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_done |=> !key_armed);
endmodule

bind wdg_keyed wdg_keyed_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sw_rst_o    (sw_rst_o),
  .ext_rst_o   (ext_rst_o),
  .en_q        (wdg_en),
  .sw_mask_q   (sw_mask),
  .to_q        (to_q),
  .stat_tout_q (stat_q[1]),
  .key_done    (key_done),
  .key_armed   (key_armed)
);

// File: tb/wdg_keyed_tb_top.sv
module wdg_keyed_tb_top;
  localparam int UT = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b1;
  logic req_i = 1'b0, we_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [15:0] wdata_i = '0, rdata_o;
  logic wait_i = 1'b0, dbg_i = 1'b0, lp_i = 1'b0;
  logic [2:0] cause_i = '0;
  logic irq_o, sw_rst_o, ext_rst_o, pd_en_o;
  int cyc = 0, total = 0, bad = 0;
  bit done = 1'b0;

  wdg_keyed #(.UNIT_TICKS(UT)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .wait_i(wait_i),
    .dbg_i(dbg_i), .lp_i(lp_i), .cause_i(cause_i), .irq_o(irq_o),
    .sw_rst_o(sw_rst_o), .ext_rst_o(ext_rst_o), .pd_en_o(pd_en_o)
  );

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] c);
    @(negedge clk_i);
    rst_ni = 1'b0; cause_i = c; tick_i = 1'b1;
    wait_i = 1'b0; dbg_i = 1'b0; lp_i = 1'b0; req_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic wait_sw(output int t);
    t = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk_i);
      if (sw_rst_o) begin t = cyc; break; end
    end
  endtask

  task automatic wait_irq(output int t);
    t = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk_i);
      if (irq_o) begin t = cyc; break; end
    end
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int t0, t1, t2;

    // R1 R2 reset values and map
    do_reset(3'b100);
    rd(4'h0, d); chk("R1 ctrl reset", d, 0);
    rd(4'h6, d); chk("R1 icr reset", d, 0);
    rd(4'h8, d); chk("R1 misc reset", d, 1);
    rd(4'h4, d); chk("R1 status por", d, 16'h0010);
    chk("R1 outputs low", {irq_o, sw_rst_o, ext_rst_o}, 0);
    chk("R13 pd_en reset", pd_en_o, 1);
    wr(4'h0, 16'h12F8);
    rd(4'h0, d); chk("R2 ctrl readback bit6 zero", d, 16'h12B8);
    rd(4'h2, d); chk("R2 service reads zero", d, 0);
    rd(4'hA, d); chk("R2 unmapped reads zero", d, 0);

    // R1 status capture sweep
    for (int c = 0; c < 8; c++) begin
      do_reset(3'(c));
      rd(4'h4, d);
      chk("R1 status capture", d, ((c >> 2) & 1) * 16 + ((c >> 1) & 1) * 2 + (c & 1));
    end

    // R3 R9 R12 timeout sweep
    for (int n = 0; n < 6; n++) begin
      do_reset(3'b000);
      wr(4'h0, {8'(n), 8'h04}); t0 = cyc;
      wait_sw(t1); chk("R3 first expiry", t1 - t0, UT * (n + 1));
      @(negedge clk_i); chk("R9 pulse one cycle", sw_rst_o, 0);
      rd(4'h4, d); chk("R12 status timeout bit", d[1], 1);
      wait_sw(t2); chk("R9 periodic expiry", t2 - t1, UT * (n + 1));
    end

    // R3 tick gating, R7 stop modes
    for (int m = 0; m < 7; m++) begin
      logic [7:0] bits;
      int stall;
      do_reset(3'b000);
      bits = (m == 1) ? 8'h84 : (m == 2) ? 8'h06 : (m == 3) ? 8'h05 : 8'h04;
      stall = (m <= 3) ? 5 : 0;
      wr(4'h0, {8'd2, bits}); t0 = cyc;
      case (m)
        0: tick_i = 1'b0;
        1, 4: wait_i = 1'b1;
        2, 5: dbg_i = 1'b1;
        default: lp_i = 1'b1;
      endcase
      repeat (5) @(negedge clk_i);
      tick_i = 1'b1; wait_i = 1'b0; dbg_i = 1'b0; lp_i = 1'b0;
      wait_sw(t1);
      chk((m == 0) ? "R3 tick gating" : "R7 stop mode", t1 - t0, UT * 3 + stall);
    end

    // R8 output selection sweep
    for (int b = 0; b < 8; b++) begin
      bit sw_seen, ext_seen;
      do_reset(3'b000);
      sw_seen = 0; ext_seen = 0;
      wr(4'h0, {8'h00, 2'b00, 3'(b), 3'b100});
      for (int i = 0; i < UT + 2; i++) begin
        @(negedge clk_i);
        if (sw_rst_o) sw_seen = 1;
        if (ext_rst_o) ext_seen = 1;
      end
      chk("R8 sw reset select", sw_seen, ((b >> 1) & 1) ? 0 : 1);
      chk("R8 ext reset select", ext_seen, ((b & 1) && !((b >> 2) & 1)) ? 1 : 0);
      rd(4'h4, d); chk("R12 status bit when masked", d[1], 1);
    end

    // R4 enable sticky
    do_reset(3'b000);
    wr(4'h0, 16'h0304); t0 = cyc;
    wr(4'h0, 16'h0300);
    rd(4'h0, d); chk("R4 enable stays set", d[2], 1);
    wait_sw(t1); chk("R4 expiry continues", t1 - t0, UT * 4);

    // R5 good key, keep-alive, interleaved write
    do_reset(3'b000);
    wr(4'h0, 16'h0304);
    repeat (4) @(negedge clk_i);
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA); t0 = cyc;
    wait_sw(t1); chk("R5 service reload", t1 - t0, UT * 4);
    do_reset(3'b000);
    wr(4'h0, 16'h0304);
    begin
      bit seen;
      seen = 0;
      for (int k = 0; k < 6; k++) begin
        wr(4'h2, 16'h5555); wr(4'h8, 16'h0001); wr(4'h2, 16'hAAAA);
        if (sw_rst_o) seen = 1;
      end
      chk("R5 keep-alive with interleaved write", seen, 0);
    end

    // R6 bad sequences: no reload
    for (int s = 0; s < 3; s++) begin
      do_reset(3'b000);
      wr(4'h0, 16'h0304); t0 = cyc;
      case (s)
        0: begin wr(4'h2, 16'h1234); wr(4'h2, 16'hAAAA); end
        1: begin wr(4'h2, 16'h5555); wr(4'h2, 16'h1234); wr(4'h2, 16'hAAAA); end
        default: begin wr(4'h2, 16'h5555); wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA); end
      endcase
      wait_sw(t1); chk("R6 bad key no reload", t1 - t0, UT * 4);
    end

    // R10 R11 interrupt lead and clear
    do_reset(3'b000);
    wr(4'h6, 16'h8002);
    wr(4'h0, 16'h0504); t0 = cyc;
    wait_irq(t1); chk("R10 irq lead point", t1 - t0, UT * 4);
    wait_sw(t2); chk("R10 irq lead time", t2 - t1, UT * 2);
    wr(4'h6, 16'h8002);
    chk("R11 write zero keeps flag", irq_o, 1);
    wr(4'h6, 16'hC002);
    chk("R11 w1c clears irq", irq_o, 0);
    rd(4'h6, d); chk("R11 icr after clear", d, 16'h8002);
    do_reset(3'b000);
    wr(4'h6, 16'h0002);
    wr(4'h0, 16'h0504);
    wait_sw(t1);
    rd(4'h6, d); chk("R10 disabled flag stays clear", d[14], 0);
    do_reset(3'b000);
    wr(4'h6, 16'h8000);
    wr(4'h0, 16'h0504);
    wait_sw(t1);
    rd(4'h6, d); chk("R10 zero lead never fires", d[14], 0);

    // R13 power-down enable
    wr(4'h8, 16'h0000);
    chk("R13 pd_en cleared", pd_en_o, 0);
    rd(4'h8, d); chk("R13 misc readback", d, 0);
    wr(4'h8, 16'h0001);
    chk("R13 pd_en set", pd_en_o, 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule